// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a countdown watchdog with a small register port. Software loads a 32-bit duration and sets the enable bit. From then on a counter steps down once per count tick. The tick comes from one of two sources. The first is an externally supplied reference tick pulse. The second is the block's own clock divided by two and then by a power of two chosen by a 3-bit ratio field, which stretches the longest timeout by up to 256 times. Software keeps the timer from expiring by rewriting the duration while the timer is enabled (a kick).

When the count runs out, the block raises a sticky expired flag and holds the counter at zero. It emits a one-cycle reset request only when two independent gates both permit it. The first is a local unmask bit, which must be set. The second is a system-level mask bit, which must be clear. The system mask bit comes out of reset set, so an expiry never resets the system unless software has opened both gates. The bus fabric, the clock source and the reset controller sit outside this block.

Top module: `wdt_timer`

## Requirements
- R1: After reset, reads return the following values. Word 0 (control) reads 0x0000_0400. Word 1 (status) reads 0. Word 2 (duration) reads 0. Word 3 (local unmask) reads 0. Word 4 (system mask) reads 0x0000_0400. Words 0, 3 and 4 read back exactly what was written.
- R2: The control word holds three fields: enable at bit 8, reference-select at bit 10 and ratio at bits 18:16. When enable goes from 0 to 1, the counter loads the full 32-bit duration, and 0xFFFF_FFFF is accepted as a duration. After exactly duration ticks, the expired flag (status bit 31) sets. A duration of 0 expires with no ticks at all: the reset request appears 2 cycles after the enabling write.
- R3: With reference-select at 0, one tick occurs every 2·2^ratio clock cycles. The first tick comes that many cycles after the control value last changed, because any change of enable, select or ratio restarts the prescaler. With an enabling write at edge W and duration D, the reset request is high in cycle W + D·2·2^ratio + 2.
- R4: With reference-select at 1, each reference tick pulse seen while enabled is one count tick, and the ratio field has no effect. If the last needed pulse is in cycle X, the reset request is high in cycle X + 2.
- R5: The expired flag stays set until software writes status with bit 31 at 0. Writing status with bit 31 at 1 leaves the flag as it is.
- R6: A duration write while enabled reloads the counter with the new value (a kick). Ticks seen before the kick no longer count.
- R7: The reset request is a single-cycle pulse. It is produced only if local unmask bit 8 is 1 and system mask bit 10 is 0 at expiry. Otherwise the expired flag still sets, but no pulse appears.
- R8: After expiry the counter stays at zero while enabled. No further pulse occurs until the counter is reloaded.
- R9: Clearing enable freezes the count, and ticks are ignored while disabled. Re-enabling reloads the duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the fast count source divided by the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 control, 1 status, 2 duration, 3 local unmask, 4 system mask) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| ref_tick | input | 1 | Single-cycle reference tick pulse, synchronous to clk |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit duration and a 3-bit ratio field. The divider therefore spans periods from 2 to 256 cycles. Short durations keep the prescaled cases to a few hundred cycles. This covers ratio 0, ratio 2 and a ratio change during a count, and in reference mode it shows that ratio 7 has no effect. Every expected reset pulse is predicted to the exact cycle, so any extra, missing or late pulse is caught. The full 32-bit duration range is covered by a write and readback only, not by counting it down.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int RATIO_W   = 3;

    // Software-visible bit positions
    localparam int EN_BIT      = 8;
    localparam int REFSEL_BIT  = 10;
    localparam int RATIO_LSB   = 16;
    localparam int EXPIRED_BIT = 31;
    localparam int UNMASK_BIT  = 8;
    localparam int SYSMASK_BIT = 10;

    // Register word indices
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUR     = 3'd2;
    localparam logic [ADDR_W-1:0] A_UNMASK  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SYSMASK = 3'd4;

    localparam logic [DATA_W-1:0] CTRL_RST    = 32'h0000_0400;
    localparam logic [DATA_W-1:0] SYSMASK_RST = 32'h0000_0400;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               use_ref;
        logic               en;
    } wdt_ctrl_t;

    function automatic wdt_ctrl_t ctrl_decode(input logic [DATA_W-1:0] raw);
        wdt_ctrl_t c;
        c.ratio   = raw[RATIO_LSB +: RATIO_W];
        c.use_ref = raw[REFSEL_BIT];
        c.en      = raw[EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic                 expire_i,
    output wdt_ctrl_t            ctrl_o,
    output logic [CNT_W-1:0]     dur_o,
    output logic                 kick_o,
    output logic                 unmask_o,
    output logic                 sysmask_o,
    output logic                 expired_o
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] unmask_q;
    logic [DATA_W-1:0] sysmask_q;
    logic [CNT_W-1:0]  dur_q;
    logic              expired_q;
    logic              kick_q;
    logic              clr_req;

    assign ctrl_o    = ctrl_decode(ctrl_q);
    assign dur_o     = dur_q;
    assign kick_o    = kick_q;
    assign unmask_o  = unmask_q[UNMASK_BIT];
    assign sysmask_o = sysmask_q[SYSMASK_BIT];
    assign expired_o = expired_q;

    assign clr_req = we_i && (addr_i == A_STATUS) && !wdata_i[EXPIRED_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RST;
            unmask_q  <= '0;
            sysmask_q <= SYSMASK_RST;
            dur_q     <= '0;
            expired_q <= 1'b0;
            kick_q    <= 1'b0;
        end else begin
            kick_q <= we_i && (addr_i == A_DUR) && ctrl_o.en;
            if (we_i) begin
                case (addr_i)
                    A_CTRL:    ctrl_q    <= wdata_i;
                    A_DUR:     dur_q     <= wdata_i[CNT_W-1:0];
                    A_UNMASK:  unmask_q  <= wdata_i;
                    A_SYSMASK: sysmask_q <= wdata_i;
                    default:   ;
                endcase
            end
            // a new expiry wins over a clear in the same cycle
            if (expire_i)     expired_q <= 1'b1;
            else if (clr_req) expired_q <= 1'b0;
        end
    end

    always_comb begin
        case (addr_i)
            A_CTRL:    rdata_o = ctrl_q;
            A_STATUS:  rdata_o = {expired_q, {(DATA_W-1){1'b0}}};
            A_DUR:     rdata_o = DATA_W'(dur_q);
            A_UNMASK:  rdata_o = unmask_q;
            A_SYSMASK: rdata_o = sysmask_q;
            default:   rdata_o = '0;
        endcase
    end

    // R5: flag persists unless software writes bit 31 low
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        expired_q && !clr_req |=> expired_q);

    // R2: an expiry event is always latched
    assert_expiry_latched_R2: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> expired_q);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wdt_ctrl_t ctrl_i,
    input  logic      ref_tick_i,
    output logic      tick_o
);

    // divider reaches 2 * 2^(2^RATIO_W - 1)
    localparam int PRE_W = (2 ** RATIO_W) + 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    wdt_ctrl_t        cfg_q;
    logic             changed;
    logic             div_hit;

    assign limit   = (PRE_W'(2) << ctrl_i.ratio) - PRE_W'(1);
    assign changed = (ctrl_i != cfg_q);
    assign div_hit = !changed && (pre_cnt == limit);
    assign tick_o  = ctrl_i.en && (ctrl_i.use_ref ? ref_tick_i : div_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            cfg_q   <= ctrl_decode(CTRL_RST);
        end else begin
            cfg_q <= ctrl_i;
            if (changed || !ctrl_i.en || ctrl_i.use_ref || div_hit)
                pre_cnt <= '0;
            else
                pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // R4: in reference mode only a reference pulse makes a tick
    assert_ref_only_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.use_ref && !ref_tick_i |-> !tick_o);

    // R9: no tick while disabled
    assert_no_tick_off_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.en |-> !tick_o);

    // R3: a configuration change restarts the divider from zero
    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        changed |=> (pre_cnt == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt;
    logic             en_q;
    logic             fired_q;
    logic             load;

    assign load     = en_i && (!en_q || kick_i);
    assign expire_o = en_i && !load && (cnt == '0) && !fired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            en_q    <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            en_q <= en_i;
            if (load) begin
                cnt     <= dur_i;
                fired_q <= 1'b0;
            end else if (en_i) begin
                if (expire_o) fired_q <= 1'b1;
                if (tick_i && (cnt != '0)) cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R2: enabling loads the programmed duration
    assert_load_on_enable_R2: assert property (@(posedge clk) disable iff (rst)
        en_i && !en_q |=> cnt == $past(dur_i));

    // R8: counter stays at zero after expiry until reloaded
    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (rst)
        en_i && en_q && !kick_i && (cnt == '0) |=> cnt == '0);

    // R9: count is frozen while disabled
    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> cnt == $past(cnt));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ref_tick,
    output logic              reset_req
);

    wdt_ctrl_t        ctrl;
    logic [CNT_W-1:0] dur;
    logic             kick;
    logic             unmask;
    logic             sysmask;
    logic             expired;
    logic             tick;
    logic             expire;
    logic             req_q;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .expire_i  (expire),
        .ctrl_o    (ctrl),
        .dur_o     (dur),
        .kick_o    (kick),
        .unmask_o  (unmask),
        .sysmask_o (sysmask),
        .expired_o (expired)
    );

    wdt_prescaler u_pre (
        .clk        (clk),
        .rst        (rst),
        .ctrl_i     (ctrl),
        .ref_tick_i (ref_tick),
        .tick_o     (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en_i     (ctrl.en),
        .tick_i   (tick),
        .kick_i   (kick),
        .dur_i    (dur),
        .expire_o (expire)
    );

    // two independent gates between expiry and the reset request
    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= expire && unmask && !sysmask;
    end

    assign reset_req = req_q;

    // R7: request lasts exactly one cycle
    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R7: request only with both gates open
    assert_gated_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(unmask && !sysmask));

    // R2: a request always comes with the expired flag
    assert_req_flag_R2: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> expired);

endmodule

// File: tb/test_wdt_timer.sv
module test_wdt_timer;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ref_tick = 1'b0;
    logic        reset_req;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    wdt_timer i_wdt_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ref_tick  (ref_tick),
        .reset_req (reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input int at, input string tag);
        exp_t e;
        e.at = at;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor: every pulse must match the oldest prediction
    always @(negedge clk) begin
        if (!rst && reset_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected reset pulse", 32'(cyc), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.at == cyc, e.tag, 32'(cyc), 32'(e.at));
            end
        end
    end

    // called at a negedge; returns the cycle index after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int w);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #1 w = cyc;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr0(input logic [2:0] a, input logic [31:0] d);
        int w;
        wr(a, d, w);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic ref_pulse(output int x);
        ref_tick = 1'b1;
        x = cyc;
        @(negedge clk);
        ref_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD / 1ns * 100000) #1ns;
        chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        int w, w2, x;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk(3'd0, 32'h0000_0400, "R1 ctrl reset");
        rd_chk(3'd1, 32'h0, "R1 status reset");
        rd_chk(3'd2, 32'h0, "R1 duration reset");
        rd_chk(3'd3, 32'h0, "R1 unmask reset");
        rd_chk(3'd4, 32'h0000_0400, "R1 sysmask reset");

        wr0(3'd3, 32'h0000_0100);
        wr0(3'd4, 32'h0);
        rd_chk(3'd3, 32'h0000_0100, "R1 unmask readback");

        // R3 ratio 0: period 2
        wr0(3'd2, 32'd3);
        wr(3'd0, 32'h0000_0100, w);
        push(w + 3*2 + 2, "R3 ratio 0 expiry cycle");
        wait_until(w + 3*2 + 4);
        rd_chk(3'd1, 32'h8000_0000, "R2 expired flag set");
        wr0(3'd1, 32'h8000_0000);
        rd_chk(3'd1, 32'h8000_0000, "R5 write one keeps flag");
        wr0(3'd1, 32'h0);
        rd_chk(3'd1, 32'h0, "R5 write zero clears flag");
        idle(20);
        rd_chk(3'd1, 32'h0, "R8 no re-expiry at zero");
        wr0(3'd0, 32'h0);

        // R3 ratio 2: period 8
        wr0(3'd2, 32'd4);
        wr(3'd0, 32'h0002_0100, w);
        push(w + 4*8 + 2, "R3 ratio 2 expiry cycle");
        wait_until(w + 4*8 + 4);
        wr0(3'd0, 32'h0);
        wr0(3'd1, 32'h0);

        // R3 ratio change restarts prescaler
        wr0(3'd2, 32'd3);
        wr(3'd0, 32'h0001_0100, w);
        wait_until(w + 4);
        wr(3'd0, 32'h0000_0100, w2);
        chk(w2 == w + 5, "R3 change timing", 32'(w2), 32'(w + 5));
        push(w2 + 6, "R3 ratio change expiry cycle");
        wait_until(w2 + 8);
        wr0(3'd0, 32'h0);
        wr0(3'd1, 32'h0);

        // R7 system mask set blocks the pulse
        wr0(3'd4, 32'h0000_0400);
        wr0(3'd2, 32'd2);
        wr(3'd0, 32'h0000_0100, w);
        wait_until(w + 6);
        rd_chk(3'd1, 32'h8000_0000, "R7 masked expiry still flags");
        wr0(3'd0, 32'h0);
        wr0(3'd1, 32'h0);
        // R7 local unmask clear blocks the pulse
        wr0(3'd4, 32'h0);
        wr0(3'd3, 32'h0);
        wr(3'd0, 32'h0000_0100, w);
        wait_until(w + 6);
        rd_chk(3'd1, 32'h8000_0000, "R7 unmasked-off expiry still flags");
        wr0(3'd0, 32'h0);
        wr0(3'd1, 32'h0);
        wr0(3'd3, 32'h0000_0100);

        // R2 duration zero
        wr0(3'd2, 32'd0);
        wr(3'd0, 32'h0000_0100, w);
        push(w + 2, "R2 zero duration expiry");
        wait_until(w + 4);
        wr0(3'd0, 32'h0);
        wr0(3'd1, 32'h0);

        // R4 reference mode, ratio 7 ignored
        wr0(3'd2, 32'd3);
        wr(3'd0, 32'h0007_0500, w);
        wait_until(w + 800);
        rd_chk(3'd1, 32'h0, "R4 no count without reference pulses");
        ref_pulse(x);
        ref_pulse(x);
        idle(3);
        ref_pulse(x);
        push(x + 2, "R4 reference mode expiry cycle");
        wait_until(x + 4);
        wr0(3'd0, 32'h0400);
        wr0(3'd1, 32'h0);

        // R6 kick reloads
        wr0(3'd2, 32'd5);
        wr(3'd0, 32'h0000_0500, w);
        idle(2);
        repeat (3) ref_pulse(x);
        wr(3'd2, 32'd4, w2);
        idle(1);
        repeat (3) ref_pulse(x);
        rd_chk(3'd1, 32'h0, "R6 kick prevents expiry");
        rd_chk(3'd2, 32'd4, "R6 kicked duration readback");
        ref_pulse(x);
        push(x + 2, "R6 expiry after kick");
        wait_until(x + 4);
        wr0(3'd0, 32'h0400);
        wr0(3'd1, 32'h0);

        // R9 disable freezes, re-enable reloads
        wr0(3'd2, 32'd5);
        wr(3'd0, 32'h0000_0500, w);
        idle(2);
        repeat (2) ref_pulse(x);
        wr0(3'd0, 32'h0000_0400);
        repeat (3) ref_pulse(x);
        rd_chk(3'd1, 32'h0, "R9 no expiry while disabled");
        wr(3'd0, 32'h0000_0500, w);
        idle(2);
        repeat (4) ref_pulse(x);
        rd_chk(3'd1, 32'h0, "R9 re-enable reloads duration");
        ref_pulse(x);
        push(x + 2, "R9 expiry after reload");
        wait_until(x + 4);
        wr0(3'd0, 32'h0400);

        // R2 full-width duration
        wr0(3'd2, 32'hFFFF_FFFF);
        rd_chk(3'd2, 32'hFFFF_FFFF, "R2 max duration readback");

        idle(5);
        chk(exp_q.size() == 0, "R7 missing predicted pulse", 32'(exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule